// File: doc/BRIEF.md
# Processor Stream Get Unit

This unit carries out stream-read instructions for a processor pipeline. The pipeline presents a request with three fields: the index of one input stream, a flag that selects blocking or non-blocking behaviour, and a flag that says whether the instruction expects an ordinary data beat or a control beat. The pipeline holds the request steady for as long as the unit raises `stall`. The unit selects one of a bank of AXI4-Stream slave inputs, takes one beat from it with a single TREADY handshake, and returns the word on `rd_data` with a one-cycle `rd_done` pulse.

The unit also drives two status updates. The carry update is written only by non-blocking reads. It is set when the selected stream had nothing to offer and cleared when a beat was taken. The stream-error update is a set-only pulse that fires when the beat's TLAST does not match the kind of instruction. A data read expects TLAST low and a control read expects TLAST high. The status register itself, writeback and decode live outside the unit.

Top module: `strm_get_unit`

## Requirements
- R1: After reset, and while no request is held, `stall`, `rd_done`, `carry_we`, `err_set` and every bit of `s_tready` are 0.
- R2: A read whose selected stream has TVALID high takes two cycles. In the first cycle `stall`=1 and TREADY is 1 on the selected port only. In the second cycle `rd_done`=1, `stall`=0, TREADY is all 0 and `rd_data` holds the beat's TDATA.
- R3: A blocking read whose stream has TVALID low keeps `stall`=1, with `rd_done`=0 and no TREADY, for every cycle until TVALID rises. From that cycle on it follows R2.
- R4: A non-blocking read whose stream has TVALID low completes in its first cycle. In that cycle `rd_done`=1, `stall`=0, `carry_we`=1, `carry_val`=1, `err_set`=0, `rd_data`=0 and no TREADY is raised, so no beat is consumed.
- R5: A non-blocking read that takes a beat has `carry_we`=1 and `carry_val`=0 in its delivery cycle.
- R6: A blocking read never asserts `carry_we`.
- R7: A data read (`req_ctrl`=0) gives `err_set`=1 in its delivery cycle when the beat's TLAST is 1, and `err_set`=0 when TLAST is 0.
- R8: A control read (`req_ctrl`=1) gives `err_set`=1 in its delivery cycle when the beat's TLAST is 0, and `err_set`=0 when TLAST is 1.
- R9: A beat with a TLAST mismatch is still consumed by exactly one handshake, and its data is still delivered.
- R10: `err_set` and `carry_we` are raised only in cycles with `rd_done`=1. `err_set` is a set request only, and the unit has no means to clear the flag.
- R11: At most one TREADY bit is high in any cycle, and never one for a port other than `req_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Get request present; held while `stall` is 1 |
| req_port | input | IDX_W (4) | Index of the stream to read |
| req_nonblock | input | 1 | 1 = non-blocking read |
| req_ctrl | input | 1 | 1 = control read (expects TLAST=1), 0 = data read |
| s_tdata | input | NUM_PORTS*DATA_W (512) | TDATA of all streams, port i at bits [i*DATA_W +: DATA_W] |
| s_tvalid | input | NUM_PORTS (16) | TVALID per stream |
| s_tlast | input | NUM_PORTS (16) | TLAST per stream |
| s_tready | output | NUM_PORTS (16) | TREADY per stream |
| rd_data | output | DATA_W (32) | Word for the destination register, valid with `rd_done` |
| rd_done | output | 1 | Instruction completes this cycle |
| stall | output | 1 | Hold the pipeline |
| carry_we | output | 1 | Write carry flag this cycle |
| carry_val | output | 1 | Value for the carry flag |
| err_set | output | 1 | Set the stream-error flag |

## Verification
The bench tries every port with all sixteen combinations of blocking mode, instruction kind, TLAST value and data presence. Blocking reads without data wait one to three cycles before TVALID rises. Every other port holds TVALID high with its own data throughout the sweep. This separates correct port selection from a TREADY or data leak onto a neighbour. The data-kind and control-kind cases with both TLAST values tell a correct mismatch test apart from an inverted one or a test that ignores the kind. Pairing present with absent data under both modes separates the one-cycle empty completion and its carry update from the two-cycle take path and from blocking stalls.

// File: rtl/strm_get_pkg.sv
package strm_get_pkg;

   typedef enum logic [0:0] {
      GS_IDLE  = 1'b0,
      GS_DELIV = 1'b1
   } get_state_e;

   typedef struct packed {
      logic nb;
      logic mism;
   } get_pend_t;

endpackage

// File: rtl/strm_port_sel.sv
module strm_port_sel #(
   parameter int NUM_PORTS = 16,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4,
   parameter bit SEL_ANDOR = 1'b1
) (
   input  logic [IDX_W-1:0]            sel_idx,
   input  logic [NUM_PORTS*DATA_W-1:0] in_data,
   input  logic [NUM_PORTS-1:0]        in_valid,
   input  logic [NUM_PORTS-1:0]        in_last,
   output logic [NUM_PORTS-1:0]        sel_onehot,
   output logic                        sel_valid,
   output logic                        sel_last,
   output logic [DATA_W-1:0]           sel_data
);

   for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_dec
      assign sel_onehot[gi] = (sel_idx == IDX_W'(gi));
   end

   if (SEL_ANDOR) begin : g_andor
      always_comb begin
         sel_data = '0;
         for (int i = 0; i < NUM_PORTS; i++) begin
            sel_data = sel_data | ({DATA_W{sel_onehot[i]}} & in_data[i*DATA_W +: DATA_W]);
         end
      end
      assign sel_valid = |(sel_onehot & in_valid);
      assign sel_last  = |(sel_onehot & in_last);
   end else begin : g_index
      logic in_range;
      assign in_range  = (int'(sel_idx) < NUM_PORTS);
      assign sel_valid = in_range && in_valid[sel_idx];
      assign sel_last  = in_range && in_last[sel_idx];
      assign sel_data  = in_range ? in_data[int'(sel_idx)*DATA_W +: DATA_W] : '0;
   end

endmodule

// File: rtl/strm_beat_reg.sv
module strm_beat_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              show,
   output logic [DATA_W-1:0] out_data
);

   logic [DATA_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      held_q <= '0;
      else if (cap_en) held_q <= cap_data;
   end

   assign out_data = show ? held_q : '0;

endmodule

// File: rtl/strm_get_ctrl.sv
module strm_get_ctrl
   import strm_get_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_nonblock,
   input  logic req_ctrl,
   input  logic sel_valid,
   input  logic sel_last,
   output logic take,
   output logic delivering,
   output logic done,
   output logic stall,
   output logic carry_we,
   output logic carry_val,
   output logic err_set
);

   get_state_e st_q, st_d;
   get_pend_t  pend_q;

   always_comb begin
      st_d      = st_q;
      take      = 1'b0;
      done      = 1'b0;
      stall     = 1'b0;
      carry_we  = 1'b0;
      carry_val = 1'b0;
      err_set   = 1'b0;
      unique case (st_q)
         GS_IDLE: begin
            if (req_valid) begin
               if (sel_valid) begin
                  take  = 1'b1;
                  stall = 1'b1;
                  st_d  = GS_DELIV;
               end else if (req_nonblock) begin
                  done      = 1'b1;
                  carry_we  = 1'b1;
                  carry_val = 1'b1;
               end else begin
                  stall = 1'b1;
               end
            end
         end
         GS_DELIV: begin
            done     = 1'b1;
            carry_we = pend_q.nb;
            err_set  = pend_q.mism;
            st_d     = GS_IDLE;
         end
         default: st_d = GS_IDLE;
      endcase
   end

   assign delivering = (st_q == GS_DELIV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= GS_IDLE;
         pend_q <= '0;
      end else begin
         st_q <= st_d;
         if (take) begin
            pend_q.nb   <= req_nonblock;
            pend_q.mism <= req_ctrl ^ sel_last;
         end
      end
   end

endmodule

// File: rtl/strm_get_unit.sv
module strm_get_unit #(
   parameter int NUM_PORTS = 16,
   parameter int DATA_W    = 32,
   parameter bit SEL_ANDOR = 1'b1,
   localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [IDX_W-1:0]            req_port,
   input  logic                        req_nonblock,
   input  logic                        req_ctrl,
   input  logic [NUM_PORTS*DATA_W-1:0] s_tdata,
   input  logic [NUM_PORTS-1:0]        s_tvalid,
   input  logic [NUM_PORTS-1:0]        s_tlast,
   output logic [NUM_PORTS-1:0]        s_tready,
   output logic [DATA_W-1:0]           rd_data,
   output logic                        rd_done,
   output logic                        stall,
   output logic                        carry_we,
   output logic                        carry_val,
   output logic                        err_set
);

   if (NUM_PORTS < 1 || NUM_PORTS > 16) begin : g_bad_ports
      $error("strm_get_unit: NUM_PORTS must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("strm_get_unit: DATA_W must be positive");
   end

   logic [NUM_PORTS-1:0] sel_onehot;
   logic                 sel_valid;
   logic                 sel_last;
   logic [DATA_W-1:0]    sel_data;
   logic                 take;
   logic                 delivering;

   strm_port_sel #(
      .NUM_PORTS (NUM_PORTS),
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .SEL_ANDOR (SEL_ANDOR)
   ) u_sel (
      .sel_idx    (req_port),
      .in_data    (s_tdata),
      .in_valid   (s_tvalid),
      .in_last    (s_tlast),
      .sel_onehot (sel_onehot),
      .sel_valid  (sel_valid),
      .sel_last   (sel_last),
      .sel_data   (sel_data)
   );

   strm_get_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_nonblock (req_nonblock),
      .req_ctrl     (req_ctrl),
      .sel_valid    (sel_valid),
      .sel_last     (sel_last),
      .take         (take),
      .delivering   (delivering),
      .done         (rd_done),
      .stall        (stall),
      .carry_we     (carry_we),
      .carry_val    (carry_val),
      .err_set      (err_set)
   );

   strm_beat_reg #(
      .DATA_W (DATA_W)
   ) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (take),
      .cap_data (sel_data),
      .show     (delivering),
      .out_data (rd_data)
   );

   assign s_tready = sel_onehot & {NUM_PORTS{take}};

endmodule

// File: rtl/strm_get_chk.sv
module strm_get_chk #(
   parameter int NUM_PORTS = 16,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [IDX_W-1:0]     req_port,
   input logic                 req_nonblock,
   input logic                 req_ctrl,
   input logic [NUM_PORTS-1:0] s_tvalid,
   input logic [NUM_PORTS-1:0] s_tlast,
   input logic [NUM_PORTS-1:0] s_tready,
   input logic [DATA_W-1:0]    rd_data,
   input logic                 rd_done,
   input logic                 stall,
   input logic                 carry_we,
   input logic                 carry_val,
   input logic                 err_set
);

   logic hs;
   assign hs = |(s_tready & s_tvalid);

   AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_tready)); // R11
   AST_READY_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (|s_tready) |-> (s_tready[req_port] && req_valid && stall)); // R11
   AST_HS_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      hs |=> (rd_done && !stall && s_tready == '0)); // R2
   AST_STALL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !rd_done); // R3
   AST_EMPTY_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_we && carry_val) |-> (rd_done && s_tready == '0 && rd_data == '0)); // R4
   AST_BLOCK_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !req_nonblock) |-> !carry_we); // R6
   AST_DATA_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && !req_ctrl) |=> (err_set == $past(|(s_tready & s_tlast)))); // R7
   AST_CTRL_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && req_ctrl) |=> (err_set == !$past(|(s_tready & s_tlast)))); // R8
   AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set || carry_we) |-> rd_done); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !rd_done) |-> (!stall && !carry_we && !err_set && s_tready == '0)); // R1

endmodule

bind strm_get_unit strm_get_chk #(
   .NUM_PORTS (NUM_PORTS),
   .DATA_W    (DATA_W),
   .IDX_W     (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_port     (req_port),
   .req_nonblock (req_nonblock),
   .req_ctrl     (req_ctrl),
   .s_tvalid     (s_tvalid),
   .s_tlast      (s_tlast),
   .s_tready     (s_tready),
   .rd_data      (rd_data),
   .rd_done      (rd_done),
   .stall        (stall),
   .carry_we     (carry_we),
   .carry_val    (carry_val),
   .err_set      (err_set)
);

// File: tb/strm_get_unit_bench.sv
module strm_get_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 16;
   localparam int DW         = 32;
   localparam int IW         = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [IW-1:0]     req_port = '0;
   logic              req_nonblock = 1'b0;
   logic              req_ctrl = 1'b0;
   logic [NP*DW-1:0]  s_tdata = '0;
   logic [NP-1:0]     s_tvalid = '0;
   logic [NP-1:0]     s_tlast = '0;
   logic [NP-1:0]     s_tready;
   logic [DW-1:0]     rd_data;
   logic              rd_done;
   logic              stall;
   logic              carry_we;
   logic              carry_val;
   logic              err_set;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strm_get_unit u_strm_get_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_port     (req_port),
      .req_nonblock (req_nonblock),
      .req_ctrl     (req_ctrl),
      .s_tdata      (s_tdata),
      .s_tvalid     (s_tvalid),
      .s_tlast      (s_tlast),
      .s_tready     (s_tready),
      .rd_data      (rd_data),
      .rd_done      (rd_done),
      .stall        (stall),
      .carry_we     (carry_we),
      .carry_val    (carry_val),
      .err_set      (err_set)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] beat_word(input int p, input int k);
      return 32'hC0DE_0000 ^ DW'(p << 8) ^ DW'(k & 8'hFF);
   endfunction

   // every other port keeps a valid beat of its own to expose leaks
   task automatic load_ports(input int p, input int k, input logic av, input logic lst);
      for (int i = 0; i < NP; i++) begin
         s_tdata[i*DW +: DW] = beat_word(i, k + 7);
         s_tvalid[i]         = 1'b1;
         s_tlast[i]          = ~lst;
      end
      s_tdata[p*DW +: DW] = beat_word(p, k);
      s_tvalid[p]         = av;
      s_tlast[p]          = lst;
   endtask

   task automatic do_get(input int p, input logic nb, input logic ctl,
                         input logic av, input logic lst, input int k);
      logic [NP-1:0] sel_bit;
      sel_bit = NP'(1) << p;
      @(negedge clk);
      load_ports(p, k, av, lst);
      req_valid    = 1'b1;
      req_port     = IW'(p);
      req_nonblock = nb;
      req_ctrl     = ctl;
      #(CLK_PERIOD/4);
      if (!av && nb) begin
         chk("R4 done",      64'(rd_done),   64'd1);
         chk("R4 stall",     64'(stall),     64'd0);
         chk("R4 carry_we",  64'(carry_we),  64'd1);
         chk("R4 carry_val", 64'(carry_val), 64'd1);
         chk("R4 err",       64'(err_set),   64'd0);
         chk("R4 data",      64'(rd_data),   64'd0);
         chk("R4 ready",     64'(s_tready),  64'd0);
      end else begin
         if (!av) begin
            for (int w = 0; w < (p % 3) + 1; w++) begin
               chk("R3 stall", 64'(stall),    64'd1);
               chk("R3 done",  64'(rd_done),  64'd0);
               chk("R3 ready", 64'(s_tready), 64'd0);
               @(negedge clk);
            end
            s_tvalid[p] = 1'b1;
            #(CLK_PERIOD/4);
         end
         chk("R2 stall", 64'(stall),    64'd1);
         chk("R2 done",  64'(rd_done),  64'd0);
         chk("R11 ready", 64'(s_tready), 64'(sel_bit));
         @(negedge clk);
         s_tvalid[p] = 1'b0;
         #(CLK_PERIOD/4);
         chk("R2 done",  64'(rd_done),  64'd1);
         chk("R2 stall", 64'(stall),    64'd0);
         chk("R2 ready", 64'(s_tready), 64'd0);
         chk("R9 data",  64'(rd_data),  64'(beat_word(p, k)));
         if (nb) begin
            chk("R5 carry_we",  64'(carry_we),  64'd1);
            chk("R5 carry_val", 64'(carry_val), 64'd0);
         end else begin
            chk("R6 carry_we",  64'(carry_we),  64'd0);
         end
         if (!ctl) chk("R7 err", 64'(err_set), 64'(lst));
         else      chk("R8 err", 64'(err_set), 64'(!lst));
      end
      @(negedge clk);
      req_valid = 1'b0;
      #(CLK_PERIOD/4);
      chk("R10 idle done", 64'(rd_done),  64'd0);
      chk("R10 idle err",  64'(err_set),  64'd0);
      chk("R10 idle cwe",  64'(carry_we), 64'd0);
   endtask

   initial begin
      int k;
      k = 0;
      repeat (3) @(negedge clk);
      #(CLK_PERIOD/4);
      chk("R1 stall", 64'(stall),    64'd0);
      chk("R1 done",  64'(rd_done),  64'd0);
      chk("R1 ready", 64'(s_tready), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      chk("R1 cwe", 64'(carry_we), 64'd0);
      chk("R1 err", 64'(err_set),  64'd0);
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 16; c++) begin
            do_get(p, c[0], c[1], c[2], c[3], k);
            k++;
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule